// File: doc/BRIEF.md
# QRSS Sync and Error Detector

This block checks a received serial stream against a quasi-random test pattern and reports whether the receiver has locked onto it. It takes one received bit per clock while its enable is high. Two pattern lengths are supported, selected by a mode input. While hunting, the local reference register is loaded directly from the received bits, so it seeds itself from the line. Once a full window of bits matches well enough, the reference stops taking input and runs on its own, and every received bit is compared against it.

Lock is judged over fixed windows of 128 enabled bits. The error count for each window saturates at the threshold and clears at every window boundary. A window with fewer than four mismatches while hunting declares lock. A window with four or more mismatches while locked drops lock, and the block goes back to hunting. The block gives two outputs. The first is a pattern-detect flag that is high while out of sync. The second is a one-cycle pulse for each mismatched bit. The block only watches the data and never alters it. The mode select must be held constant while the block is enabled.

Top module: `qrss_sync_det`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), pd is 1 and bit_err is 0.
- R2: At every clock edge where det_en is 0, the detector is cleared: the reference history is set to zeros, the window and error counts restart, and hunting resumes. The cycle after such an edge shows pd = 1 and bit_err = 0.
- R3: The pattern recurrence is b[n] = b[n-17] XOR b[n-20] when cept_sel = 0 (the 2^20-1 sequence), and b[n] = b[n-14] XOR b[n-15] when cept_sel = 1 (the 2^15-1 sequence). A stream built with the other recurrence never locks.
- R4: Every enabled bit is compared with an expected value. bit_err is 1 in the cycle after each enabled bit that differs from that value. While hunting, the expected value is the recurrence applied to the previously received bits, with bits from before enable taken as 0. A single flipped bit therefore gives three pulses while hunting.
- R5: A window is 128 consecutive enabled bits, counted from the first enabled bit after disable or reset. pd changes only at the edge that samples the 128th bit of a window, or at a disabled edge.
- R6: When a hunting window ends with fewer than 4 mismatches, pd falls to 0 and the reference switches to free-running.
- R7: When a locked window ends with 4 or more mismatches, pd rises to 1 and hunting resumes. From the next bit on, the reference is reseeded from received data. A locked window with only 3 mismatches keeps lock.
- R8: While locked, the reference shifts in its own predicted bit. A single corrupted bit gives exactly one bit_err pulse.
- R9: Mismatch counts do not carry over between windows. Two errors at the end of one window and two at the start of the next keep lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one received bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| det_en | input | 1 | Detector enable; low clears and holds the detector |
| cept_sel | input | 1 | 0 selects the 2^20-1 pattern, 1 selects the 2^15-1 pattern |
| rx_bit | input | 1 | Received data bit |
| pd | output | 1 | Pattern detect; 1 means out of sync |
| bit_err | output | 1 | One-cycle pulse per mismatched bit, one cycle after the bit |

## Verification
The hardest case to reach from the ports is error placement relative to the window boundary. Four errors that straddle two windows must keep lock, while the same four errors inside one window must drop it. The bench counts enabled bits itself, pads the stream up to a boundary, and then places flipped bits at chosen offsets. A second hard case is telling the hunting response from the locked response to one flipped bit. The bench flips a bit early in the first window after enable, in the short span after the history has filled, and counts three pulses there. It then counts exactly one pulse for a flip placed inside a locked window.

// File: rtl/qrss_det_pkg.sv
// Shared types and pattern constants for the QRSS sync and error detector.
// Assumes the tap positions below describe the two supported recurrences.
package qrss_det_pkg;

    typedef enum logic {
        SYNC_HUNT = 1'b0,
        SYNC_LOCK = 1'b1
    } sync_state_e;

    // Recurrence b[n] = b[n-NEAR] ^ b[n-FAR] for each pattern length
    localparam int DSX_TAP_NEAR  = 17;
    localparam int DSX_TAP_FAR   = 20;
    localparam int CEPT_TAP_NEAR = 14;
    localparam int CEPT_TAP_FAR  = 15;

endpackage

// File: rtl/qrss_ref_lfsr.sv
// Reference pattern register. While hunting, it shifts in received bits so it
// seeds itself from the line. While free-running, it shifts in its own
// prediction. Assumes HIST_W covers the farthest tap of both recurrences.
module qrss_ref_lfsr
    import qrss_det_pkg::*;
#(
    parameter int HIST_W = DSX_TAP_FAR
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic cept_sel,
    input  logic free_run,
    input  logic rx_bit,
    output logic exp_bit
);

    logic [HIST_W-1:0] hist;
    logic              dsx_pred;
    logic              cept_pred;
    logic              shift_in;

    // Predict the next bit from the history for both recurrences
    always_comb begin
        dsx_pred  = hist[DSX_TAP_NEAR-1]  ^ hist[DSX_TAP_FAR-1];
        cept_pred = hist[CEPT_TAP_NEAR-1] ^ hist[CEPT_TAP_FAR-1];
        exp_bit   = cept_sel ? cept_pred : dsx_pred;
        shift_in  = free_run ? exp_bit : rx_bit;
    end

    // History register; bit 0 holds the most recent bit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hist <= '0;
        end else if (adv) begin
            hist <= {hist[HIST_W-2:0], shift_in};
        end
    end

endmodule

// File: rtl/qrss_win_cnt.sv
// Window counter. Counts enabled bits in fixed windows and counts mismatches,
// saturating at the threshold. It flags the last bit of each window and
// whether that window reached the threshold. Assumes bit_err is qualified by adv.
module qrss_win_cnt #(
    parameter int WIN_LEN   = 128,
    parameter int ERR_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic bit_err,
    output logic win_end,
    output logic win_bad
);

    localparam int CNT_W = $clog2(WIN_LEN);
    localparam int ERR_W = $clog2(ERR_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WIN_LEN - 1);
    localparam logic [ERR_W-1:0] ERR_MAX  = ERR_W'(ERR_LIMIT);

    logic [CNT_W-1:0] bit_cnt;
    logic [ERR_W-1:0] err_cnt;
    logic [ERR_W-1:0] err_next;

    // Saturating error sum including the current bit, and end-of-window flags
    always_comb begin
        err_next = (bit_err && (err_cnt != ERR_MAX)) ? err_cnt + 1'b1 : err_cnt;
        win_end  = adv && (bit_cnt == LAST_POS);
        win_bad  = (err_next == ERR_MAX);
    end

    // Bit position inside the current window
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bit_cnt <= '0;
        end else if (adv) begin
            bit_cnt <= win_end ? '0 : bit_cnt + 1'b1;
        end
    end

    // Mismatch count for the current window, cleared at each boundary
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err_cnt <= '0;
        end else if (adv) begin
            err_cnt <= win_end ? '0 : err_next;
        end
    end

    // R9
    err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= ERR_MAX);

    // R9
    win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (err_cnt == '0));

endmodule

// File: rtl/qrss_lock_fsm.sv
// Lock state machine. Moves from hunting to locked on a good window and back
// on a bad one. A clear returns it to hunting. Assumes the window flags
// are valid only together with win_end.
module qrss_lock_fsm
    import qrss_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic win_end,
    input  logic win_bad,
    output logic locked
);

    sync_state_e state_q;

    // Next-state decision taken at window boundaries only
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q <= SYNC_HUNT;
        end else if (win_end) begin
            case (state_q)
                SYNC_HUNT: if (!win_bad) state_q <= SYNC_LOCK;
                SYNC_LOCK: if (win_bad)  state_q <= SYNC_HUNT;
                default:                 state_q <= SYNC_HUNT;
            endcase
        end
    end

    // Lock flag for the datapath and status output
    always_comb locked = (state_q == SYNC_LOCK);

    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(win_end && !win_bad && !clr));

    // R7
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(clr || (win_end && win_bad)));

endmodule

// File: rtl/qrss_sync_det.sv
// QRSS sync and error detector top. Compares each enabled received bit with
// the reference, pulses bit_err on each mismatch and drives pd high while
// out of sync. Assumes cept_sel is held constant while det_en is high.
module qrss_sync_det
    import qrss_det_pkg::*;
#(
    parameter int WIN_LEN   = 128,
    parameter int ERR_LIMIT = 4,
    parameter int HIST_W    = DSX_TAP_FAR
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic cept_sel,
    input  logic rx_bit,
    output logic pd,
    output logic bit_err
);

    logic exp_bit;
    logic mismatch;
    logic win_end;
    logic win_bad;
    logic locked;
    logic clr;

    // Clear everything while disabled; flag mismatch on enabled bits
    always_comb begin
        clr      = !det_en;
        mismatch = det_en && (exp_bit != rx_bit);
    end

    qrss_ref_lfsr #(
        .HIST_W   (HIST_W)
    ) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .adv      (det_en),
        .cept_sel (cept_sel),
        .free_run (locked),
        .rx_bit   (rx_bit),
        .exp_bit  (exp_bit)
    );

    qrss_win_cnt #(
        .WIN_LEN   (WIN_LEN),
        .ERR_LIMIT (ERR_LIMIT)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .adv     (det_en),
        .bit_err (mismatch),
        .win_end (win_end),
        .win_bad (win_bad)
    );

    qrss_lock_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .win_end (win_end),
        .win_bad (win_bad),
        .locked  (locked)
    );

    // Registered per-bit error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_err <= 1'b0;
        end else begin
            bit_err <= mismatch;
        end
    end

    // Pattern detect is high whenever not locked
    always_comb pd = !locked;

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> (pd && !bit_err));

    // R5
    pd_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pd) |-> $past(win_end || !det_en));

endmodule

// File: tb/qrss_sync_det_test.sv
`timescale 1ns/1ps
module qrss_sync_det_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_en = 1'b0;
    logic cept_sel = 1'b0;
    logic rx_bit = 1'b0;
    logic pd;
    logic bit_err;

    qrss_sync_det uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .det_en   (det_en),
        .cept_sel (cept_sel),
        .rx_bit   (rx_bit),
        .pd       (pd),
        .bit_err  (bit_err)
    );

    always #2.5 clk = ~clk;

    int  n_checks = 0;
    int  n_errors = 0;
    int  pulse_cnt = 0;
    bit  done = 1'b0;

    task automatic check(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   hist_q[$];
    bit   m_locked = 1'b0;
    int   m_pos = 0;
    int   m_errs = 0;
    logic m_pd = 1'b1;
    logic m_err = 1'b0;
    bit   m_exp;
    int   t_near;
    int   t_far;

    function automatic bit hb(input int k);
        return (hist_q.size() >= k) ? hist_q[k-1][0] : 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || !det_en) begin
            hist_q.delete();
            m_locked = 1'b0;
            m_pos    = 0;
            m_errs   = 0;
            m_pd     = 1'b1;
            m_err    = 1'b0;
        end else begin
            t_near = cept_sel ? 14 : 17;
            t_far  = cept_sel ? 15 : 20;
            m_exp  = hb(t_near) ^ hb(t_far);
            m_err  = (m_exp != rx_bit);
            if (m_err) m_errs++;
            hist_q.push_front(m_locked ? int'(m_exp) : int'(rx_bit));
            if (hist_q.size() > 20) void'(hist_q.pop_back());
            m_pos++;
            if (m_pos == 128) begin
                if (!m_locked && m_errs < 4) m_locked = 1'b1;
                else if (m_locked && m_errs >= 4) m_locked = 1'b0;
                m_pos  = 0;
                m_errs = 0;
            end
            m_pd = !m_locked;
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 pd vs model", pd, m_pd);
            check("R4 bit_err vs model", bit_err, m_err);
            if (bit_err === 1'b1) pulse_cnt++;
        end
    end

    // ---------------- stimulus ----------------
    int gen_q[$];
    bit gen_cept = 1'b0;
    int en_count = 0;
    int flip_q[$];

    function automatic bit next_gen();
        int  nr;
        int  fr;
        bit  b;
        nr = gen_cept ? 14 : 17;
        fr = gen_cept ? 15 : 20;
        b  = gen_q[nr-1][0] ^ gen_q[fr-1][0];
        gen_q.push_front(int'(b));
        if (gen_q.size() > 20) void'(gen_q.pop_back());
        return b;
    endfunction

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            bit b;
            bit f;
            b = next_gen();
            f = 1'b0;
            foreach (flip_q[j]) if (flip_q[j] == i) f = 1'b1;
            rx_bit = b ^ f;
            det_en = 1'b1;
            @(posedge clk);
            #1;
            en_count++;
        end
    endtask

    task automatic align();
        send((128 - (en_count % 128)) % 128);
    endtask

    task automatic disable_det();
        det_en = 1'b0;
        @(posedge clk);
        #1;
        en_count = 0;
    endtask

    initial begin
        for (int i = 0; i < 20; i++) gen_q.push_back(1);
        gen_cept = 1'b0;
        repeat (500) void'(next_gen());

        repeat (3) @(posedge clk);
        #1;
        check("R1 pd after reset", pd, 1'b1);
        check("R1 bit_err after reset", bit_err, 1'b0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R2 pd while disabled", pd, 1'b1);

        // 2^20-1 stream locks after clean windows
        cept_sel = 1'b0;
        send(384);
        check("R6 lock on 2^20-1 stream", pd, 1'b0);

        // Single flip while locked gives one pulse
        align();
        pulse_cnt = 0;
        flip_q = '{50};
        send(128);
        flip_q.delete();
        check_int("R8 one pulse per flip when locked", pulse_cnt, 1);
        check("R8 lock kept", pd, 1'b0);

        // Three errors in one window keep lock
        align();
        flip_q = '{5, 40, 90};
        send(128);
        flip_q.delete();
        check("R7 three errors keep lock", pd, 1'b0);

        // Two plus two across a boundary keep lock
        align();
        flip_q = '{100, 120, 130, 140};
        send(256);
        flip_q.delete();
        check("R9 split errors keep lock", pd, 1'b0);

        // Four errors in one window drop lock
        align();
        flip_q = '{10, 20, 30, 40};
        send(128);
        flip_q.delete();
        check("R7 four errors drop lock", pd, 1'b1);

        // Reseed and relock on the next clean window
        send(128);
        check("R7 relock after reseed", pd, 1'b0);

        // Hunting response to one flip in 2^15-1 mode
        disable_det();
        check("R2 pd after disable", pd, 1'b1);
        check("R2 bit_err after disable", bit_err, 1'b0);
        gen_cept = 1'b1;
        cept_sel = 1'b1;
        send(40);
        pulse_cnt = 0;
        flip_q = '{10};
        send(80);
        flip_q.delete();
        check_int("R4 three pulses per flip when hunting", pulse_cnt, 3);
        check("R4 still hunting", pd, 1'b1);
        send(8);
        send(128);
        check("R3 lock on 2^15-1 stream", pd, 1'b0);

        // Wrong recurrence never locks
        disable_det();
        gen_cept = 1'b0;
        cept_sel = 1'b1;
        send(512);
        check("R3 mismatched mode stays unlocked", pd, 1'b1);

        // Relock, then disable clears state
        disable_det();
        cept_sel = 1'b0;
        send(384);
        check("R6 lock again on 2^20-1", pd, 1'b0);
        disable_det();
        check("R2 disable forces pd", pd, 1'b1);
        send(127);
        check("R5 pd held until window end", pd, 1'b1);

        det_en = 1'b0;
        @(posedge clk);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule